// File: doc/BRIEF.md
# Dual-Network Redundancy Manager

This block sits behind two independent receive networks, A and B, which both carry every frame of one virtual link. Each network delivers descriptors that have already passed that network's own integrity checks: a valid strobe, an 8-bit sequence number and a handle that points at stored payload. The block forwards upstream whichever copy of a sequence number shows up first and drops the copy that comes later. If network B presents the same number in the same cycle as network A, network A wins.

A programmable skew limit, counted in clock cycles, sets how long the block keeps a record of a delivered frame while it waits for that frame's twin. When no twin arrives before the limit runs out, the record is cleared and a timeout is counted. Forwarding carries on as normal after a timeout.

Forwarded descriptors go into a small queue and leave through a valid/ready handshake. A descriptor that has been accepted is never lost while downstream stalls. Two saturating counters report the frames that were discarded and the skew timeouts that occurred.

Top module: `redundancy_merge`

## Requirements
- R1: After reset, outValid, discardCnt and timeoutCnt are 0. The first frame after reset is forwarded whatever its sequence number.
- R2: With P as the last forwarded number, a frame from either network is forwarded when its number is succ(P) or succ(succ(P)), where succ(255)=1 and succ(n)=n+1 otherwise. Forwarding sets P to that number. outFromB is 0 for network A and 1 for network B, and outHandle carries that network's handle.
- R3: A frame with a nonzero number outside that window is discarded and adds 1 to discardCnt. This covers the twin equal to P and stale or jumped numbers.
- R4: When both networks present the same acceptable number in one cycle, the A copy is forwarded and the B copy is discarded and counted.
- R5: When both networks present different numbers in one cycle, A is judged first. B is then judged against the updated P, and if both are accepted A is delivered before B.
- R6: Number 0 is always accepted as a restart and sets P to 0. The only exception is when P is already 0; its twin is then discarded.
- R7: Losing one frame on one or both networks does not stop delivery: number P+2 is still forwarded.
- R8: If no copy equal to P arrives within skewLimit cycles after P was forwarded, timeoutCnt rises by 1 on the clock edge exactly skewLimit cycles after the forwarding edge.
- R9: A twin that arrives on the skewLimit-th cycle after forwarding counts as in time and causes no timeout. A twin that arrives after a timeout is discarded and counted, and causes no second timeout.
- R10: While outValid is 1 and outReady is 0, outSeq, outHandle and outFromB stay stable. Descriptors leave in the order they were accepted.
- R11: A new frame that arrives while DEPTH descriptors are queued is not accepted, not counted, and leaves P unchanged, so its twin can still be forwarded later.
- R12: discardCnt and timeoutCnt saturate at all ones, including when discardCnt would gain 2 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aValid | input | 1 | Network A descriptor strobe |
| aSeq | input | 8 | Network A sequence number |
| aHandle | input | HANDLE_W | Network A payload handle |
| bValid | input | 1 | Network B descriptor strobe |
| bSeq | input | 8 | Network B sequence number |
| bHandle | input | HANDLE_W | Network B payload handle |
| skewLimit | input | SKEW_W | Twin wait limit in cycles |
| outValid | output | 1 | Forwarded descriptor available |
| outReady | input | 1 | Downstream accepts the descriptor |
| outSeq | output | 8 | Forwarded sequence number |
| outHandle | output | HANDLE_W | Forwarded payload handle |
| outFromB | output | 1 | 1 when the descriptor came from network B |
| discardCnt | output | CNT_W | Saturating count of discarded frames |
| timeoutCnt | output | CNT_W | Saturating count of skew timeouts |

## Verification
The main function is driven with several kinds of input:
- Alternating winners, to show that forwarding follows whichever network arrives first.
- Trailing twins, to separate a discarded duplicate from a forwarded frame.
- Skipped and stale numbers, to test the two-wide window and its wrap that skips 0.
- A restart frame and its twin.
- Same-cycle pairs with equal and with different numbers, to show the A-first order.

The skew timer is probed one cycle before and at the limit, and with a twin on the last permitted cycle, so an off-by-one in either direction shows up. A stalled output, filled to the depth of the queue, shows whether a frame is refused or silently dropped.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

  typedef struct packed {
    logic pushA;
    logic pushB;
  } rdmPush_t;

  function automatic logic [7:0] nextSn(input logic [7:0] p);
    return (p == 8'd255) ? 8'd1 : p + 8'd1;
  endfunction

  function automatic logic isFresh(input logic [7:0] s, input logic havePsn,
                                   input logic [7:0] p);
    if (s == 8'd0) return !(havePsn && p == 8'd0);
    if (!havePsn) return 1'b1;
    return (s == nextSn(p)) || (s == nextSn(nextSn(p)));
  endfunction

endpackage

// File: rtl/rdm_ctrl.sv
module rdm_ctrl
  import rdm_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 3,
  parameter int SKEW_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  input  logic [7:0]        aSeq,
  input  logic              bValid,
  input  logic [7:0]        bSeq,
  input  logic [SKEW_W-1:0] skewLimit,
  input  logic [LVL_W-1:0]  level,
  output rdmPush_t          push,
  output logic [CNT_W-1:0]  discardCnt,
  output logic [CNT_W-1:0]  timeoutCnt
);
  localparam int CW1 = CNT_W + 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE_LESS = LVL_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic              havePsn, pending;
  logic [7:0]        psn;
  logic [SKEW_W-1:0] timer;

  logic freshA, accA, haveMid, freshB, accB, dropA, dropB, twinA, twinB;
  logic [7:0] psnMid;
  logic [CW1-1:0] dropSum;

  always_comb begin
    freshA  = aValid && isFresh(aSeq, havePsn, psn);
    accA    = freshA && (level < FULL_LVL);
    haveMid = havePsn | accA;
    psnMid  = accA ? aSeq : psn;
    freshB  = bValid && isFresh(bSeq, haveMid, psnMid);
    accB    = freshB && (accA ? (level < ONE_LESS) : (level < FULL_LVL));
    dropA   = aValid && !freshA;
    dropB   = bValid && !freshB;
    twinA   = dropA && pending && (aSeq == psn);
    twinB   = dropB && (accA ? (bSeq == aSeq) : (pending && bSeq == psn));
    dropSum = {1'b0, discardCnt} + CW1'(dropA) + CW1'(dropB);
    push.pushA = accA;
    push.pushB = accB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePsn    <= 1'b0;
      psn        <= '0;
      pending    <= 1'b0;
      timer      <= '0;
      discardCnt <= '0;
      timeoutCnt <= '0;
    end else begin
      discardCnt <= dropSum[CNT_W] ? CNT_MAX : dropSum[CNT_W-1:0];
      if (accA || accB) begin
        havePsn <= 1'b1;
        psn     <= accB ? bSeq : aSeq;
        timer   <= skewLimit;
        pending <= !(accA && !accB && twinB);
      end else if (pending) begin
        if (twinA || twinB) begin
          pending <= 1'b0;
        end else if (timer <= SKEW_W'(1)) begin
          pending <= 1'b0;
          if (timeoutCnt != CNT_MAX) timeoutCnt <= timeoutCnt + 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  // R4
  aPriority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && bValid && aSeq == bSeq) |-> !push.pushB);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && aSeq == 8'd0 && !(havePsn && psn == 8'd0) && level < FULL_LVL)
      |-> push.pushA);

  // R12
  dropSat_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> discardCnt >= $past(discardCnt));

  // R8
  timeoutCause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutCnt != $past(timeoutCnt)) |-> $past(pending));

endmodule

// File: rtl/rdm_dp.sv
module rdm_dp
  import rdm_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int HANDLE_W = 16,
  parameter int LVL_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdmPush_t            push,
  input  logic [7:0]          aSeq,
  input  logic [HANDLE_W-1:0] aHandle,
  input  logic [7:0]          bSeq,
  input  logic [HANDLE_W-1:0] bHandle,
  input  logic                outReady,
  output logic                outValid,
  output logic [7:0]          outSeq,
  output logic [HANDLE_W-1:0] outHandle,
  output logic                outFromB,
  output logic [LVL_W-1:0]    level
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]          seqMem [DEPTH];
  logic [HANDLE_W-1:0] hndMem [DEPTH];
  logic                netMem [DEPTH];
  logic [AW-1:0]       wrPtr, rdPtr, bSlot;
  logic                pop;

  assign outValid  = (level != '0);
  assign pop       = outValid && outReady;
  assign bSlot     = wrPtr + AW'(push.pushA);
  assign outSeq    = seqMem[rdPtr];
  assign outHandle = hndMem[rdPtr];
  assign outFromB  = netMem[rdPtr];

  always_ff @(posedge clk) begin
    if (push.pushA) begin
      seqMem[wrPtr] <= aSeq;
      hndMem[wrPtr] <= aHandle;
      netMem[wrPtr] <= 1'b0;
    end
    if (push.pushB) begin
      seqMem[bSlot] <= bSeq;
      hndMem[bSlot] <= bHandle;
      netMem[bSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(push.pushA) + AW'(push.pushB);
      rdPtr <= rdPtr + AW'(pop);
      level <= level + LVL_W'(push.pushA) + LVL_W'(push.pushB) - LVL_W'(pop);
    end
  end

  // R11
  noOverflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_W'(DEPTH)) |-> !(push.pushA || push.pushB));

  // R10
  holdOut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSeq) &&
                                 $stable(outHandle) && $stable(outFromB)));

endmodule

// File: rtl/redundancy_merge.sv
module redundancy_merge
  import rdm_pkg::*;
#(
  parameter int HANDLE_W = 16,
  parameter int DEPTH    = 4,
  parameter int SKEW_W   = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                aValid,
  input  logic [7:0]          aSeq,
  input  logic [HANDLE_W-1:0] aHandle,
  input  logic                bValid,
  input  logic [7:0]          bSeq,
  input  logic [HANDLE_W-1:0] bHandle,
  input  logic [SKEW_W-1:0]   skewLimit,
  output logic                outValid,
  input  logic                outReady,
  output logic [7:0]          outSeq,
  output logic [HANDLE_W-1:0] outHandle,
  output logic                outFromB,
  output logic [CNT_W-1:0]    discardCnt,
  output logic [CNT_W-1:0]    timeoutCnt
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  rdmPush_t         push;
  logic [LVL_W-1:0] level;

  rdm_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W), .SKEW_W(SKEW_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aSeq(aSeq), .bValid(bValid),
    .bSeq(bSeq), .skewLimit(skewLimit), .level(level), .push(push),
    .discardCnt(discardCnt), .timeoutCnt(timeoutCnt)
  );

  rdm_dp #(.DEPTH(DEPTH), .HANDLE_W(HANDLE_W), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .push(push), .aSeq(aSeq), .aHandle(aHandle),
    .bSeq(bSeq), .bHandle(bHandle), .outReady(outReady), .outValid(outValid),
    .outSeq(outSeq), .outHandle(outHandle), .outFromB(outFromB), .level(level)
  );

endmodule

// File: tb/redundancy_merge_tb.sv
`timescale 1ns/1ps
module redundancy_merge_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aValid = 1'b0, bValid = 1'b0, outReady = 1'b1;
  logic [7:0]  aSeq = '0, bSeq = '0;
  logic [15:0] aHandle, bHandle;
  logic [15:0] skewLimit = 16'd1000;
  logic        outValid, outFromB;
  logic [7:0]  outSeq, discardCnt, timeoutCnt;
  logic [15:0] outHandle;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  assign aHandle = {8'hA0, aSeq};
  assign bHandle = {8'hB0, bSeq};

  redundancy_merge u_dut (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aSeq(aSeq), .aHandle(aHandle),
    .bValid(bValid), .bSeq(bSeq), .bHandle(bHandle), .skewLimit(skewLimit),
    .outValid(outValid), .outReady(outReady), .outSeq(outSeq),
    .outHandle(outHandle), .outFromB(outFromB), .discardCnt(discardCnt),
    .timeoutCnt(timeoutCnt)
  );

  // {req4, aV, aSeq8, bV, bSeq8, expValid, expSeq8, expFromB, expDiscard8}
  localparam logic [39:0] VECS [15] = '{
    {4'd1, 1'b1, 8'd254, 1'b0, 8'd0,   1'b1, 8'd254, 1'b0, 8'd0}, // R1 any first SN
    {4'd3, 1'b0, 8'd0,   1'b1, 8'd254, 1'b0, 8'd0,   1'b0, 8'd1}, // R3 twin
    {4'd2, 1'b1, 8'd1,   1'b0, 8'd0,   1'b1, 8'd1,   1'b0, 8'd1}, // R2 wrap skips 0
    {4'd3, 1'b0, 8'd0,   1'b1, 8'd255, 1'b0, 8'd0,   1'b0, 8'd2}, // R3 stale
    {4'd2, 1'b0, 8'd0,   1'b1, 8'd2,   1'b1, 8'd2,   1'b1, 8'd2}, // R2 B first
    {4'd3, 1'b1, 8'd2,   1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 8'd3}, // R3 A late
    {4'd7, 1'b1, 8'd4,   1'b0, 8'd0,   1'b1, 8'd4,   1'b0, 8'd3}, // R7 skip of 3
    {4'd3, 1'b0, 8'd0,   1'b1, 8'd4,   1'b0, 8'd0,   1'b0, 8'd4}, // R3 twin
    {4'd4, 1'b1, 8'd5,   1'b1, 8'd5,   1'b1, 8'd5,   1'b0, 8'd5}, // R4 tie to A
    {4'd3, 1'b1, 8'd9,   1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 8'd6}, // R3 jump
    {4'd2, 1'b0, 8'd0,   1'b1, 8'd6,   1'b1, 8'd6,   1'b1, 8'd6}, // R2
    {4'd6, 1'b1, 8'd0,   1'b0, 8'd0,   1'b1, 8'd0,   1'b0, 8'd6}, // R6 restart
    {4'd6, 1'b0, 8'd0,   1'b1, 8'd0,   1'b0, 8'd0,   1'b0, 8'd7}, // R6 restart twin
    {4'd6, 1'b1, 8'd1,   1'b0, 8'd0,   1'b1, 8'd1,   1'b0, 8'd7}, // R6 after restart
    {4'd2, 1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 8'd0,   1'b0, 8'd7}  // R2 idle
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic av, input logic [7:0] as, input logic bv,
                       input logic [7:0] bs);
    aValid = av; aSeq = as; bValid = bv; bSeq = bs;
    step();
    aValid = 1'b0; bValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
  endtask

  initial begin
    logic [39:0] v;
    doReset();
    check("R1 outValid after reset", outValid, 0);
    check("R1 discardCnt after reset", discardCnt, 0);
    check("R1 timeoutCnt after reset", timeoutCnt, 0);

    for (int i = 0; i < 15; i++) begin
      v = VECS[i];
      drive(v[35], v[34:27], v[26], v[25:18]);
      check($sformatf("R%0d row%0d valid", v[39:36], i), outValid, v[17]);
      if (v[17]) begin
        check($sformatf("R%0d row%0d seq", v[39:36], i), outSeq, v[16:9]);
        check($sformatf("R%0d row%0d net", v[39:36], i), outFromB, v[8]);
        check($sformatf("R%0d row%0d handle", v[39:36], i), outHandle,
              {(v[8] ? 8'hB0 : 8'hA0), v[16:9]});
      end
      check($sformatf("R%0d row%0d discards", v[39:36], i), discardCnt, v[7:0]);
    end
    check("R8 no timeout in table", timeoutCnt, 0);

    // R8: timeout exactly skewLimit cycles after forwarding
    skewLimit = 16'd4;
    doReset();
    drive(1'b1, 8'd7, 1'b0, 8'd0);
    idle(3);
    check("R8 no timeout one cycle early", timeoutCnt, 0);
    step();
    check("R8 timeout at limit", timeoutCnt, 1);
    step();
    drive(1'b0, 8'd0, 1'b1, 8'd7);
    check("R9 late twin discarded", discardCnt, 1);
    check("R9 late twin no output", outValid, 0);
    idle(6);
    check("R9 no second timeout", timeoutCnt, 1);

    // R9: twin on the last permitted cycle
    drive(1'b1, 8'd8, 1'b0, 8'd0);
    idle(3);
    drive(1'b0, 8'd0, 1'b1, 8'd8);
    idle(6);
    check("R9 in-time twin no timeout", timeoutCnt, 1);
    check("R9 in-time twin discarded", discardCnt, 2);

    // R5: two distinct new numbers in one cycle
    drive(1'b1, 8'd9, 1'b1, 8'd10);
    check("R5 first out seq", outSeq, 9);
    check("R5 first out net", outFromB, 0);
    step();
    check("R5 second out valid", outValid, 1);
    check("R5 second out seq", outSeq, 10);
    check("R5 second out net", outFromB, 1);
    step();
    check("R5 queue empty", outValid, 0);

    // R10 / R11: stalled output, queue fills
    outReady = 1'b0;
    for (int s = 11; s <= 14; s++) drive(1'b1, 8'(s), 1'b0, 8'd0);
    check("R10 held seq", outSeq, 11);
    drive(1'b1, 8'd15, 1'b0, 8'd0);
    drive(1'b0, 8'd0, 1'b1, 8'd15);
    check("R11 refused not counted", discardCnt, 2);
    check("R10 still held", outSeq, 11);
    check("R10 still valid", outValid, 1);
    outReady = 1'b1;
    for (int s = 12; s <= 14; s++) begin
      step();
      check("R10 drain order", outSeq, s);
    end
    step();
    check("R11 refused frame not queued", outValid, 0);
    drive(1'b0, 8'd0, 1'b1, 8'd15);
    check("R11 twin after refusal valid", outValid, 1);
    check("R11 twin after refusal seq", outSeq, 15);
    check("R11 twin after refusal net", outFromB, 1);

    // R12: saturation with two discards per cycle
    for (int k = 0; k < 140; k++) drive(1'b1, 8'd15, 1'b1, 8'd15);
    check("R12 discard saturates", discardCnt, 255);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule